// File: doc/BRIEF.md
# Row-Sequential Sampled Inference Controller

This block runs inference on a stack of memory arrays in which every row stores one sampled model of a probabilistic network. It drives a one-hot row-select word that enables the same row index in every array at once. One forward pass therefore uses only that row's model. For each row it waits for a programmable settle interval and then pulses a sample strobe. On the strobe it captures the digitized activation of every output neuron into a per-output sample buffer, and it adds the value to a running sum and sum of squares. The row select drops for one cycle before the next row is driven.

After the last row it reports, for each output class, a mean and a spread figure. The spread is N times the sum of squares minus the square of the sum, which is N squared times the variance and needs no square root. It also reports the class with the highest mean and an abstain flag. The abstain flag is raised when the spread of the chosen class exceeds a programmable standard-deviation threshold, scaled to the same units. The analog arrays, neuron circuits and converters sit outside the block.

Top module: `sample_infer_ctrl`

## Requirements
- R1: While reset is held and right after it, row_sel is all zero and busy, res_valid and sample_strobe are low.
- R2: At most one bit of row_sel is ever high. row_sel is all zero in the cycle that follows every sample strobe.
- R3: Rows are visited in the order 0, 1, ..., N_ROWS-1, with bit r of row_sel selecting row r. Each row is driven for settle_cycles+1 cycles without the strobe, then for one more cycle with sample_strobe high and the same row still selected.
- R4: On the strobe cycle of row r, act_in (output o at bits [o*DW +: DW]) is stored. Afterwards samp_data returns, without a clock delay, the stored word of the row given on samp_addr, in the same packing.
- R5: At res_valid, mean_out field o holds floor(sum of the N_ROWS samples of output o / N_ROWS).
- R6: At res_valid, unc_out field o (VW bits each) holds N_ROWS*Σx² − (Σx)² over the samples of output o.
- R7: At res_valid, class_out is the output with the highest sample sum. On a tie the lower index wins.
- R8: At res_valid, abstain is 1 exactly when the unc_out value of the predicted class is strictly greater than (thresh*N_ROWS)².
- R9: busy rises in the cycle after an accepted start and stays high until res_valid. res_valid is a one-cycle pulse with busy low, and busy stays low after it.
- R10: An accepted start clears all sums, so results depend only on the current run. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| settle_cycles | input | SW | Extra settle cycles per row |
| thresh | input | DW | Standard-deviation limit for abstain |
| act_in | input | N_OUT*DW | Digitized output activations |
| samp_addr | input | RW | Row index for sample buffer read |
| row_sel | output | N_ROWS | One-hot row enable for all arrays |
| sample_strobe | output | 1 | Capture cycle for the current row |
| busy | output | 1 | Run in progress |
| res_valid | output | 1 | One-cycle result pulse |
| samp_data | output | N_OUT*DW | Stored samples of row samp_addr |
| mean_out | output | N_OUT*DW | Per-class mean |
| unc_out | output | N_OUT*VW | Per-class scaled variance |
| class_out | output | CW | Predicted class |
| abstain | output | 1 | Uncertainty above limit |

## Verification
The properties assume that settle_cycles and thresh stay constant from start to res_valid. They also assume that act_in is stable in the strobe cycle and that start is a single-cycle pulse. The bench meets these conditions by setting both configuration values before each start and leaving them untouched until the result. Its converter model drives act_in combinationally from the selected row. It drives a distinct junk pattern whenever no row is selected, so a capture at the wrong time shows up in the sums.

// File: rtl/sic_pkg.sv
package sic_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETTLE, ST_STROBE, ST_GAP, ST_DONE
  } sic_state_t;

  // N * sum(x^2) - (sum x)^2 : N^2 times the population variance
  function automatic logic [63:0] spread_f(input logic [63:0] n,
                                           input logic [63:0] s,
                                           input logic [63:0] q);
    return n * q - s * s;
  endfunction

  // threshold on standard deviation, moved into spread units
  function automatic logic [63:0] limit_f(input logic [63:0] n,
                                          input logic [63:0] t);
    return (t * n) * (t * n);
  endfunction
endpackage

// File: rtl/sic_row_seq.sv
module sic_row_seq
  import sic_pkg::*;
#(
  parameter int N_ROWS = 8,
  parameter int SW     = 8,
  localparam int RW    = $clog2(N_ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SW-1:0]     settle_cycles,
  output logic [N_ROWS-1:0] row_sel,
  output logic [RW-1:0]     row_idx,
  output logic              strobe,
  output logic              busy,
  output logic              done,
  output logic              clr
);
  sic_state_t    state;
  logic [SW-1:0] cnt;
  logic          last_row;

  assign last_row = (row_idx == RW'(N_ROWS - 1));
  assign clr      = (state == ST_IDLE) && start;
  assign strobe   = (state == ST_STROBE);
  assign done     = (state == ST_DONE);
  assign busy     = (state == ST_SETTLE) || (state == ST_STROBE) || (state == ST_GAP);
  assign row_sel  = ((state == ST_SETTLE) || (state == ST_STROBE))
                    ? (N_ROWS'(1) << row_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      row_idx <= '0;
      cnt     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_SETTLE;
          row_idx <= '0;
          cnt     <= '0;
        end
        ST_SETTLE: begin
          if (cnt >= settle_cycles) state <= ST_STROBE;
          else cnt <= cnt + SW'(1);
        end
        ST_STROBE: state <= ST_GAP;
        ST_GAP: begin
          if (last_row) state <= ST_DONE;
          else begin
            row_idx <= row_idx + RW'(1);
            cnt     <= '0;
            state   <= ST_SETTLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sic_accum.sv
module sic_accum #(
  parameter int N_ROWS = 8,
  parameter int N_OUT  = 2,
  parameter int DW     = 8,
  localparam int RW    = $clog2(N_ROWS),
  localparam int SUMW  = DW + RW,
  localparam int SQW   = 2 * DW + RW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  strobe,
  input  logic [RW-1:0]         row_idx,
  input  logic [N_OUT*DW-1:0]   act_in,
  input  logic [RW-1:0]         rd_row,
  output logic [N_OUT*DW-1:0]   rd_data,
  output logic [N_OUT*SUMW-1:0] sum_flat,
  output logic [N_OUT*SQW-1:0]  sumsq_flat
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [DW-1:0]   samp_buf [N_ROWS];
    logic [SUMW-1:0] sum_q;
    logic [SQW-1:0]  sumsq_q;
    logic [DW-1:0]   x;

    assign x = act_in[o*DW +: DW];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_q   <= '0;
        sumsq_q <= '0;
      end else if (clr) begin
        sum_q   <= '0;
        sumsq_q <= '0;
      end else if (strobe) begin
        sum_q   <= sum_q + SUMW'(x);
        sumsq_q <= sumsq_q + SQW'(x) * SQW'(x);
      end
    end

    always_ff @(posedge clk) begin
      if (strobe) samp_buf[row_idx] <= x;
    end

    assign rd_data[o*DW +: DW]        = samp_buf[rd_row];
    assign sum_flat[o*SUMW +: SUMW]   = sum_q;
    assign sumsq_flat[o*SQW +: SQW]   = sumsq_q;
  end
endmodule

// File: rtl/sic_decide.sv
module sic_decide
  import sic_pkg::*;
#(
  parameter int N_ROWS = 8,
  parameter int N_OUT  = 2,
  parameter int DW     = 8,
  localparam int RW    = $clog2(N_ROWS),
  localparam int CW    = $clog2(N_OUT),
  localparam int SUMW  = DW + RW,
  localparam int SQW   = 2 * DW + RW,
  localparam int VW    = 2 * (DW + RW)
) (
  input  logic [N_OUT*SUMW-1:0] sum_flat,
  input  logic [N_OUT*SQW-1:0]  sumsq_flat,
  input  logic [DW-1:0]         thresh,
  output logic [N_OUT*DW-1:0]   mean_flat,
  output logic [N_OUT*VW-1:0]   unc_flat,
  output logic [CW-1:0]         class_idx,
  output logic                  abstain
);
  logic [VW-1:0] limit;
  logic [VW-1:0] best_unc;

  for (genvar o = 0; o < N_OUT; o++) begin : g_stat
    assign mean_flat[o*DW +: DW] = DW'(sum_flat[o*SUMW +: SUMW] >> RW);
    assign unc_flat[o*VW +: VW]  = VW'(spread_f(64'(N_ROWS),
                                                 64'(sum_flat[o*SUMW +: SUMW]),
                                                 64'(sumsq_flat[o*SQW +: SQW])));
  end

  always_comb begin
    logic [SUMW-1:0] best_sum;
    class_idx = '0;
    best_sum  = sum_flat[0 +: SUMW];
    for (int o = 1; o < N_OUT; o++) begin
      if (sum_flat[o*SUMW +: SUMW] > best_sum) begin
        best_sum  = sum_flat[o*SUMW +: SUMW];
        class_idx = CW'(o);
      end
    end
  end

  assign limit    = VW'(limit_f(64'(N_ROWS), 64'(thresh)));
  assign best_unc = unc_flat[class_idx*VW +: VW];
  assign abstain  = (best_unc > limit);
endmodule

// File: rtl/sample_infer_ctrl.sv
module sample_infer_ctrl #(
  parameter int N_ROWS = 8,
  parameter int N_OUT  = 2,
  parameter int DW     = 8,
  parameter int SW     = 8,
  localparam int RW    = $clog2(N_ROWS),
  localparam int CW    = $clog2(N_OUT),
  localparam int VW    = 2 * (DW + RW)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [SW-1:0]       settle_cycles,
  input  logic [DW-1:0]       thresh,
  input  logic [N_OUT*DW-1:0] act_in,
  input  logic [RW-1:0]       samp_addr,
  output logic [N_ROWS-1:0]   row_sel,
  output logic                sample_strobe,
  output logic                busy,
  output logic                res_valid,
  output logic [N_OUT*DW-1:0] samp_data,
  output logic [N_OUT*DW-1:0] mean_out,
  output logic [N_OUT*VW-1:0] unc_out,
  output logic [CW-1:0]       class_out,
  output logic                abstain
);
  localparam int SUMW = DW + RW;
  localparam int SQW  = 2 * DW + RW;

  logic [RW-1:0]         row_idx;
  logic                  clr;
  logic [N_OUT*SUMW-1:0] sum_flat;
  logic [N_OUT*SQW-1:0]  sumsq_flat;

  sic_row_seq #(.N_ROWS(N_ROWS), .SW(SW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
    .row_sel(row_sel), .row_idx(row_idx), .strobe(sample_strobe),
    .busy(busy), .done(res_valid), .clr(clr)
  );

  sic_accum #(.N_ROWS(N_ROWS), .N_OUT(N_OUT), .DW(DW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .strobe(sample_strobe),
    .row_idx(row_idx), .act_in(act_in), .rd_row(samp_addr),
    .rd_data(samp_data), .sum_flat(sum_flat), .sumsq_flat(sumsq_flat)
  );

  sic_decide #(.N_ROWS(N_ROWS), .N_OUT(N_OUT), .DW(DW)) u_dec (
    .sum_flat(sum_flat), .sumsq_flat(sumsq_flat), .thresh(thresh),
    .mean_flat(mean_out), .unc_flat(unc_out), .class_idx(class_out),
    .abstain(abstain)
  );
endmodule

// File: rtl/sic_chk.sv
module sic_chk #(
  parameter int N_ROWS = 8,
  parameter int N_OUT  = 2,
  parameter int DW     = 8,
  localparam int CW    = $clog2(N_OUT)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic [N_ROWS-1:0]   row_sel,
  input logic                sample_strobe,
  input logic                busy,
  input logic                res_valid,
  input logic [N_OUT*DW-1:0] mean_out,
  input logic [CW-1:0]       class_out
);
  assert_row_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_sel));

  assert_gap_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |=> (row_sel == '0));

  assert_strobe_holds_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> (row_sel != '0) && $stable(row_sel));

  assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !busy ##1 (!res_valid && !busy));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (row_sel == '0) && !sample_strobe);

  for (genvar o = 0; o < N_OUT; o++) begin : g_max
    assert_class_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> mean_out[class_out*DW +: DW] >= mean_out[o*DW +: DW]);
  end
endmodule

bind sample_infer_ctrl sic_chk #(.N_ROWS(N_ROWS), .N_OUT(N_OUT), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .row_sel(row_sel),
  .sample_strobe(sample_strobe), .busy(busy), .res_valid(res_valid),
  .mean_out(mean_out), .class_out(class_out)
);

// File: tb/sample_infer_ctrl_bench.sv
module sample_infer_ctrl_bench;
  localparam int N  = 8;
  localparam int NO = 2;
  localparam int DW = 8;
  localparam int SW = 8;
  localparam int RW = 3;
  localparam int VW = 2 * (DW + RW);
  localparam int NV = 5;

  // row r occupies bits [r*16 +: 16] as {class1, class0}
  localparam logic [127:0] SAMP [NV] = '{
    128'h3264_3264_3264_3264_3264_3264_3264_3264,
    128'h1E28_1E3C_1E28_1E3C_1E28_1E3C_1E28_1E3C,
    128'h1E28_1E3C_1E28_1E3C_1E28_1E3C_1E28_1E3C,
    128'h4646_3C3C_3232_2828_1E1E_1414_0A0A_0000,
    128'hFF00_FFFF_FF00_FFFF_FF00_FFFF_FF00_FFFF
  };
  localparam int SETL [NV] = '{2, 0, 1, 3, 0};
  localparam int THR  [NV] = '{0, 10, 9, 255, 0};

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [SW-1:0] settle_cycles = '0;
  logic [DW-1:0] thresh = '0;
  logic [NO*DW-1:0] act_in;
  logic [RW-1:0] samp_addr = '0;
  logic [N-1:0] row_sel;
  logic sample_strobe, busy, res_valid, abstain;
  logic [NO*DW-1:0] samp_data, mean_out;
  logic [NO*VW-1:0] unc_out;
  logic class_out;

  int total = 0;
  int bad = 0;
  int vec_now = 0;
  int cur_settle = 0;
  bit mon_en = 0;
  int exp_row = 0;
  int run_len = 0;
  bit prev_strobe = 0;

  always #4 clk = ~clk;

  sample_infer_ctrl u_sample_infer_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
    .thresh(thresh), .act_in(act_in), .samp_addr(samp_addr),
    .row_sel(row_sel), .sample_strobe(sample_strobe), .busy(busy),
    .res_valid(res_valid), .samp_data(samp_data), .mean_out(mean_out),
    .unc_out(unc_out), .class_out(class_out), .abstain(abstain)
  );

  // converter model: junk whenever no row is enabled
  always_comb begin
    act_in = 16'hA5A5;
    for (int r = 0; r < N; r++)
      if (row_sel[r]) act_in = SAMP[vec_now][r*16 +: 16];
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (prev_strobe) chk(row_sel == '0, "R2 gap after strobe", row_sel, 0);
      chk($countones(row_sel) <= 1, "R2 one-hot", row_sel, 0);
      if (sample_strobe) begin
        chk(row_sel == N'(1 << exp_row), "R3 row order", row_sel, 1 << exp_row);
        chk(run_len == cur_settle + 1, "R3 settle length", run_len, cur_settle + 1);
        exp_row++;
        run_len = 0;
      end else if (row_sel != '0) run_len++;
      prev_strobe = sample_strobe;
    end
  end

  task automatic run_vec(input int v, input bit restart);
    longint s [NO];
    longint q [NO];
    longint u [NO];
    int best;
    int n;
    vec_now = v;
    cur_settle = SETL[v];
    settle_cycles = SW'(SETL[v]);
    thresh = DW'(THR[v]);
    exp_row = 0; run_len = 0; prev_strobe = 0; mon_en = 1;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(busy == 1'b1, "R9 busy after start", busy, 1);
    if (restart) begin
      repeat (3) @(negedge clk);
      start = 1;
      @(negedge clk) start = 0;
      chk(busy == 1'b1, "R10 start while busy ignored", busy, 1);
    end
    n = 0;
    while (!res_valid && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(res_valid == 1'b1, "R9 result pulse seen", res_valid, 1);
    chk(busy == 1'b0, "R9 busy low at result", busy, 0);
    chk(exp_row == N, "R3 all rows visited", exp_row, N);
    for (int o = 0; o < NO; o++) begin
      s[o] = 0; q[o] = 0;
      for (int r = 0; r < N; r++) begin
        longint x;
        x = SAMP[v][r*16 + o*8 +: 8];
        s[o] += x;
        q[o] += x * x;
      end
      u[o] = N * q[o] - s[o] * s[o];
      chk(mean_out[o*DW +: DW] == DW'(s[o] / N), "R5 mean", mean_out[o*DW +: DW], s[o] / N);
      chk(unc_out[o*VW +: VW] == VW'(u[o]), "R6 spread / R10 cleared", unc_out[o*VW +: VW], u[o]);
    end
    best = 0;
    for (int o = 1; o < NO; o++) if (s[o] > s[best]) best = o;
    chk(int'(class_out) == best, "R7 predicted class", class_out, best);
    chk(abstain == (u[best] > longint'(THR[v] * N) * longint'(THR[v] * N)),
        "R8 abstain", abstain, u[best] > longint'(THR[v] * N) * longint'(THR[v] * N));
    @(negedge clk);
    chk(res_valid == 1'b0 && busy == 1'b0, "R9 single pulse", {res_valid, busy}, 0);
    mon_en = 0;
    for (int r = 0; r < N; r++) begin
      samp_addr = RW'(r);
      #1;
      chk(samp_data == SAMP[v][r*16 +: 16], "R4 sample buffer", samp_data, SAMP[v][r*16 +: 16]);
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(row_sel == '0 && !busy && !res_valid && !sample_strobe, "R1 reset state",
        {row_sel, busy, res_valid, sample_strobe}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(row_sel == '0 && !busy && !res_valid && !sample_strobe, "R1 after reset",
        {row_sel, busy, res_valid, sample_strobe}, 0);
    for (int v = 0; v < NV; v++) run_vec(v, 1'b0);
    // corner: extra start mid-run, and a rerun after a different vector
    run_vec(1, 1'b1);
    run_vec(0, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule